// File: doc/BRIEF.md
# Power-of-Two Result Scaler

This block multiplies a binary32 value by an integer power of two. It is the last step of a division or square-root sequence that was first run on operands moved into a safe exponent range. The earlier stage produces a 10-bit correction word. The nine low bits of that word are a signed exponent offset, and the top bit is a flag that forces a NaN result. The scaler adds the offset to the value's exponent and leaves the sign and fraction alone. It then turns any out-of-range result into a signed infinity or a signed zero. Results that would be subnormal are flushed to zero.

The earlier stage sends special-case operands through this block with extreme offsets. The most negative offset drives every normal value to zero. The largest offset drives every normal value to infinity. In both cases the value's sign is kept. The block is a one-stage pipeline: a result appears one clock after its operands are accepted.

Top module: `pow2_scaler`

## Requirements
- R1: During reset and right after it, out_valid is 0 and out_value is 32'h00000000.
- R2: A beat presented with in_valid high appears on out_value one clock later, with out_valid high in that cycle. out_valid is low in every cycle that follows a cycle where in_valid was low.
- R3: When in_k[9] is 1, the result is the quiet NaN 32'h7FC00000, whatever in_value holds.
- R4: For a normal input (biased exponent in_value[30:23] from 1 to 254), with in_k[9]=0, the new exponent is the old one plus in_k[8:0] read as two's complement. When that sum lies between 1 and 254, the sign bit (31) and the fraction (22:0) pass through unchanged.
- R5: When the sum for a normal input is 255 or more, the result is an infinity: the input's sign, exponent 8'hFF, fraction 0.
- R6: When the sum for a normal input is 0 or less, the result is a zero carrying the input's sign.
- R7: in_k[8:0]=9'h100 (-256) sends every normal input to a signed zero. in_k[8:0]=9'h0FF (+255) sends every normal input to a signed infinity.
- R8: An input with biased exponent 0 (zero or subnormal) gives a zero of the input's sign when in_k[9]=0.
- R9: An input with biased exponent 255 (infinity or NaN) comes out bit for bit unchanged when in_k[9]=0.
- R10: While in_valid is low, out_value keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat present |
| in_value | input | 32 | binary32 value to scale |
| in_k | input | 10 | Bit 9: NaN force; bits 8..0: signed exponent offset |
| out_valid | output | 1 | Result present |
| out_value | output | 32 | Scaled binary32 result |

## Verification
The bound checker tests on every cycle that the pipeline has one stage of latency and that the output holds during idle cycles. It also checks that a forced NaN comes out, that the sign is kept whenever no NaN is forced, and that infinity and NaN inputs pass through unchanged. The exact exponent arithmetic cannot be seen by those properties. That includes the 254/255 and 1/0 boundaries of the sum, the extreme offsets, and flushing of subnormal inputs. These are shown only by the bench's directed and random scenarios, which it compares against a flush-to-zero ldexp model.

// File: rtl/pow2_scaler.sv
module pow2_scaler #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int K_W    = 10,
  localparam int DATA_W = 1 + EXP_W + FRAC_W,
  localparam int SUM_W  = EXP_W + 3,
  localparam int EXP_MAX = (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [K_W-1:0]    in_k,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_value
);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic signed [SUM_W-1:0] sum;
  logic [DATA_W-1:0] res;

  assign sgn = in_value[DATA_W-1];
  assign ex  = in_value[DATA_W-2:FRAC_W];
  assign fr  = in_value[FRAC_W-1:0];
  assign sum = $signed({{(SUM_W-EXP_W){1'b0}}, ex})
             + $signed({{(SUM_W-K_W+1){in_k[K_W-2]}}, in_k[K_W-2:0]});

  always_comb begin
    if (in_k[K_W-1])
      res = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    else if (ex == EXP_W'(EXP_MAX))
      res = in_value;
    else if (ex == '0 || sum <= 0)
      res = {sgn, {(DATA_W-1){1'b0}}};
    else if (sum >= SUM_W'(EXP_MAX))
      res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      res = {sgn, sum[EXP_W-1:0], fr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_value <= res;
    end
  end

endmodule

module pow2_scaler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_value,
  input logic [9:0]  in_k,
  input logic        out_valid,
  input logic [31:0] out_value
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_nan_force: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_k[9]) |=> (out_value == 32'h7FC00000));

  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_k[9]) |=> (out_value[31] == $past(in_value[31])));

  a_r9_special_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_k[9] && in_value[30:23] == 8'hFF) |=> (out_value == $past(in_value)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_value));

endmodule

bind pow2_scaler pow2_scaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
  .in_k(in_k), .out_valid(out_valid), .out_value(out_value)
);

// File: tb/pow2_scaler_bench.sv
`timescale 1ns/1ps
module pow2_scaler_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] in_value = '0;
  logic [9:0]  in_k = '0;
  logic        out_valid;
  logic [31:0] out_value;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_val = '0;

  always #2 clk = ~clk;

  pow2_scaler u_pow2_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_k(in_k), .out_valid(out_valid), .out_value(out_value)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] v, input logic [9:0] k);
    int e;
    int off;
    if (k[9]) return 32'h7FC00000;
    e = int'(v[30:23]);
    if (e == 255) return v;
    if (e == 0) return {v[31], 31'd0};
    off = k[8] ? int'(k[8:0]) - 512 : int'(k[8:0]);
    e = e + off;
    if (e >= 255) return {v[31], 8'hFF, 23'd0};
    if (e <= 0) return {v[31], 31'd0};
    return {v[31], e[7:0], v[22:0]};
  endfunction

  task automatic drive(input logic [31:0] v, input logic [9:0] k, input string tag);
    @(negedge clk);
    in_valid = 1;
    in_value = v;
    in_k = k;
    exp_q.push_back(model(v, k));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      in_value = $urandom;
      in_k = 10'($urandom);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected result", out_value, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_value == e, t, out_value, e);
      end
      last_val = out_value;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", {31'd0, out_valid}, 32'h0);
    check(out_value == 0, "R1 value in reset", out_value, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 valid after reset", {31'd0, out_valid}, 32'h0);

    drive(32'h3F800000, 10'h003, "R4 1.0 times 8");
    drive(32'hC0490FDB, 10'h1FE, "R4 negative offset -2");
    drive(32'h3F800000, 10'h07F, "R4 reach exponent 254");
    drive(32'h3F800000, 10'h080, "R5 reach exponent 255");
    drive(32'hBF800000, 10'h0A0, "R5 negative overflow");
    drive(32'h3F800000, 10'h182, "R4 reach exponent 1");
    drive(32'hBF800000, 10'h181, "R6 reach exponent 0");
    drive(32'h00800000, 10'h1FF, "R6 smallest normal down");
    drive(32'h7F7FFFFF, 10'h100, "R7 -256 on largest normal");
    drive(32'h80800000, 10'h100, "R7 -256 on negative smallest");
    drive(32'h00800000, 10'h0FF, "R7 +255 on smallest normal");
    drive(32'hFF7FFFFF, 10'h0FF, "R7 +255 on negative largest");
    drive(32'h12345678, 10'h200, "R3 NaN force normal");
    drive(32'h80000000, 10'h3FF, "R3 NaN force zero");
    drive(32'h7F800000, 10'h2FF, "R3 NaN force inf");
    drive(32'h00000000, 10'h0FF, "R8 positive zero");
    drive(32'h80000000, 10'h100, "R8 negative zero");
    drive(32'h00012345, 10'h050, "R8 subnormal flushed");
    drive(32'h807FFFFF, 10'h0FF, "R8 negative subnormal");
    drive(32'h7F800000, 10'h100, "R9 inf passes");
    drive(32'hFF800000, 10'h0FF, "R9 negative inf passes");
    drive(32'h7FA00001, 10'h010, "R9 signalling NaN passes");
    drive(32'hFFC00000, 10'h1F0, "R9 quiet NaN passes");
    idle(1);
    check(out_valid == 1, "R2 last beat valid", {31'd0, out_valid}, 32'h1);
    @(negedge clk);
    check(out_valid == 0, "R2 idle gives no valid", {31'd0, out_valid}, 32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] v;
      logic [9:0] k;
      v = $urandom;
      k = 10'($urandom);
      if (i % 4 != 0) k[9] = 0;
      if (i % 3 == 0) k[8:0] = 9'($signed(k[4:0]));
      drive(v, k, "R4 random ldexp");
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(2);
    begin
      logic [31:0] held;
      held = out_value;
      check(held == last_val, "R10 value after drain", held, last_val);
      idle(5);
      check(out_value == held, "R10 hold while idle", out_value, held);
    end
    check(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule